// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in the transmit path of an Ethernet MAC and fills in a 16-bit ones'-complement checksum that software has asked for. Each frame is announced by a short command on a byte-wide control stream. The command carries an enable flag, the byte at which summing begins, the byte at which the result is to be written, and a seed that is folded into the sum. This lets one engine serve IPv4, TCP or UDP checksums without parsing any headers.

The frame bytes then arrive on a byte-wide data stream. They are written into a local buffer while the running sum is built. When the last byte is in, the engine decides whether the frame may be sent at all. That decision depends on the transmit enable and on the standard and VLAN-tagged size limits. A frame that is allowed out is replayed on an output stream, with the two checksum bytes substituted on the fly. Each frame that is sent adds its length to a 64-bit byte counter and raises a one-cycle completion flag.

Top module: `csum_tx_engine`

## Requirements
- R1: A command is exactly 20 control bytes (five 32-bit words, each sent least-significant byte first). Bit 0 of word 0 enables insertion. Word 1 bits 31:16 hold the start offset and bits 15:0 hold the write offset. Word 2 bits 15:0 hold the seed. No data byte is accepted until a complete command has arrived.
- R2: A command whose terminating byte is not the 20th byte raises `ctl_err` for one cycle, starting in the cycle after that byte. The command is discarded, and the engine keeps waiting for a new command with `din_ready` low.
- R3: The checksum is computed over stored bytes from the start offset to the frame end, paired as big-endian 16-bit words counted from the start offset. A trailing odd byte is padded with zero. The seed is added, carries are folded back until 16 bits remain, and the result is inverted. The high byte replaces the byte at the write offset and the low byte replaces the byte after it. All other bytes are unchanged.
- R4: With insertion disabled, the frame is replayed byte for byte unmodified.
- R5: When write offset + 1 is not below the stored frame length, no byte is modified. When it is exactly one below, both bytes are patched.
- R6: If `cfg_tx_en` is low when the last data byte is taken, the frame is discarded. No output appears and the byte counter is unchanged.
- R7: With `cfg_jumbo_en` and `cfg_vlan_en` both low, frames of 1519 to 1522 bytes are discarded. Frames of 1518 or 1523 bytes are sent. Either enable lets the 1519 to 1522 byte frames through.
- R8: After the last output byte is accepted, `tx_bytes` grows by the sent length and `tx_sent` is high for exactly one cycle. `tx_bytes` changes at no other time.
- R9: The buffer holds 4096 bytes. Bytes past that are taken and dropped. The replayed frame, the sum and the count cover only the first 4096 bytes.
- R10: While `dout_valid` is high and `dout_ready` is low, `dout_data` and `dout_last` hold their values.
- R11: After reset, `tx_bytes` is zero, `dout_valid`, `tx_sent`, `ctl_err` and `din_ready` are low, and `ctl_ready` is high.
- R12: When the start offset is at or beyond the frame end, the inserted value is the inverted seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Transmit enable, checked at frame end |
| cfg_jumbo_en | input | 1 | Lift the 1519 to 1522 byte drop window |
| cfg_vlan_en | input | 1 | Allow tagged-size frames of 1519 to 1522 bytes |
| ctl_valid | input | 1 | Command byte valid |
| ctl_ready | output | 1 | Engine accepts command bytes |
| ctl_data | input | 8 | Command byte |
| ctl_last | input | 1 | Final command byte |
| din_valid | input | 1 | Frame byte valid |
| din_ready | output | 1 | Engine accepts frame bytes |
| din_data | input | 8 | Frame byte |
| din_last | input | 1 | Final frame byte |
| dout_valid | output | 1 | Output byte valid |
| dout_ready | input | 1 | Downstream accepts output byte |
| dout_data | output | 8 | Output byte |
| dout_last | output | 1 | Final output byte |
| ctl_err | output | 1 | One-cycle malformed-command flag |
| tx_sent | output | 1 | One-cycle frame-sent flag |
| tx_bytes | output | 64 | Running count of transmitted bytes |

## Verification
The bench builds the engine with its default parameters: a 4096-byte buffer, the 1518/1522 size window, five command words and a 64-bit counter. With these values, both edges of the size-drop window can be reached using real frame lengths. A 4100-byte frame takes the buffer past its capacity, so the truncation path and a patch placed at the very last stored byte are both exercised. The short frames cover odd and even start offsets, odd frame lengths, a write offset at the frame boundary, and a start offset past the end.

// File: rtl/csum_tx_pkg.sv
package csum_tx_pkg;

  typedef enum logic [2:0] {
    ST_CTL,
    ST_DATA,
    ST_EVAL,
    ST_RD,
    ST_LD,
    ST_OUT
  } eng_state_t;

  typedef struct packed {
    logic        ins_en;
    logic [15:0] start_off;
    logic [15:0] wr_off;
    logic [15:0] seed;
  } csum_cmd_t;

endpackage

// File: rtl/csum_ctl_assembler.sv
module csum_ctl_assembler
  import csum_tx_pkg::*;
#(
  parameter int WORDS = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      take,
  input  logic [7:0] byte_in,
  input  logic      last_in,
  output logic      good,
  output logic      bad,
  output csum_cmd_t cmd
);

  localparam int NBYTES = 4 * WORDS;
  localparam int CW     = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] FINAL  = CW'(NBYTES - 1);
  localparam logic [CW-1:0] CAP    = CW'(NBYTES);
  // byte positions inside the payload, little-endian words
  localparam logic [CW-1:0] B_FLAG = CW'(0);
  localparam logic [CW-1:0] B_WR   = CW'(4);
  localparam logic [CW-1:0] B_ST   = CW'(6);
  localparam logic [CW-1:0] B_SEED = CW'(8);

  logic [CW-1:0] cnt_q;

  assign good = take && last_in && (cnt_q == FINAL);
  assign bad  = take && last_in && (cnt_q != FINAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take) begin
      if (last_in)          cnt_q <= '0;
      else if (cnt_q != CAP) cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
    end else if (take) begin
      case (cnt_q)
        B_FLAG:           cmd.ins_en          <= byte_in[0];
        B_WR:             cmd.wr_off[7:0]     <= byte_in;
        B_WR + CW'(1):    cmd.wr_off[15:8]    <= byte_in;
        B_ST:             cmd.start_off[7:0]  <= byte_in;
        B_ST + CW'(1):    cmd.start_off[15:8] <= byte_in;
        B_SEED:           cmd.seed[7:0]       <= byte_in;
        B_SEED + CW'(1):  cmd.seed[15:8]      <= byte_in;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/csum_frame_ram.sv
module csum_frame_ram #(
  parameter int DEPTH = 4096,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/csum_accum.sv
module csum_accum #(
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          add_en,
  input  logic [LW-1:0] pos,
  input  logic [7:0]    byte_in,
  input  logic [15:0]   start_off,
  input  logic [15:0]   seed,
  output logic [15:0]   csum
);

  localparam int XW = ((LW > 16) ? LW : 16) + 1;

  logic [31:0]   acc_q;
  logic [XW-1:0] pos_x, start_x;
  logic          in_win, lo_half;
  logic [31:0]   addend, total;
  logic [16:0]   fold1;
  logic [15:0]   fold2;

  always_comb begin
    pos_x   = XW'(pos);
    start_x = XW'(start_off);
    in_win  = pos_x >= start_x;
    lo_half = pos_x[0] ^ start_x[0];
    addend  = lo_half ? {24'd0, byte_in} : {16'd0, byte_in, 8'd0};
  end

  always_ff @(posedge clk) begin
    if (rst || clr)            acc_q <= '0;
    else if (add_en && in_win) acc_q <= acc_q + addend;
  end

  always_comb begin
    total = acc_q + {16'd0, seed};
    fold1 = {1'b0, total[15:0]} + {1'b0, total[31:16]};
    fold2 = fold1[15:0] + {15'd0, fold1[16]};
    csum  = ~fold2;
  end

endmodule

// File: rtl/csum_tx_engine.sv
module csum_tx_engine
  import csum_tx_pkg::*;
#(
  parameter int DEPTH     = 4096,
  parameter int STD_MAX   = 1518,
  parameter int VLAN_MAX  = 1522,
  parameter int CTL_WORDS = 5,
  parameter int CNT_W     = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_tx_en,
  input  logic             cfg_jumbo_en,
  input  logic             cfg_vlan_en,
  input  logic             ctl_valid,
  output logic             ctl_ready,
  input  logic [7:0]       ctl_data,
  input  logic             ctl_last,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  input  logic             din_last,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_data,
  output logic             dout_last,
  output logic             ctl_err,
  output logic             tx_sent,
  output logic [CNT_W-1:0] tx_bytes
);

  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int XW = ((LW > 16) ? LW : 16) + 1;

  eng_state_t    state_q;
  csum_cmd_t     cmd;
  logic          cmd_good, cmd_bad;
  logic          ctl_take, din_take, store;
  logic [LW-1:0] cnt_q, rd_q;
  logic [7:0]    ram_q, out_byte;
  logic [15:0]   csum_now, csum_q;
  logic          patch_q, drop;
  logic [XW-1:0] rd_x, wo_x;
  logic          dv_q, dl_q, sent_q, err_q;
  logic [7:0]    dd_q;
  logic [CNT_W-1:0] bytes_q;

  assign ctl_ready = (state_q == ST_CTL);
  assign din_ready = (state_q == ST_DATA);
  assign ctl_take  = ctl_valid && ctl_ready;
  assign din_take  = din_valid && din_ready;
  assign store     = din_take && (cnt_q != LW'(DEPTH));

  csum_ctl_assembler #(.WORDS(CTL_WORDS)) u_ctl (
    .clk(clk), .rst(rst), .take(ctl_take), .byte_in(ctl_data),
    .last_in(ctl_last), .good(cmd_good), .bad(cmd_bad), .cmd(cmd)
  );

  csum_frame_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(store), .waddr(cnt_q[AW-1:0]), .wdata(din_data),
    .raddr(rd_q[AW-1:0]), .rdata(ram_q)
  );

  csum_accum #(.LW(LW)) u_sum (
    .clk(clk), .rst(rst), .clr(ctl_ready), .add_en(store), .pos(cnt_q),
    .byte_in(din_data), .start_off(cmd.start_off), .seed(cmd.seed),
    .csum(csum_now)
  );

  always_comb begin
    drop = !cfg_tx_en ||
           (!cfg_jumbo_en && !cfg_vlan_en &&
            (32'(cnt_q) > 32'(STD_MAX)) && (32'(cnt_q) <= 32'(VLAN_MAX)));
    rd_x = XW'(rd_q);
    wo_x = XW'(cmd.wr_off);
    if (patch_q && rd_x == wo_x)                  out_byte = csum_q[15:8];
    else if (patch_q && rd_x == wo_x + XW'(1))    out_byte = csum_q[7:0];
    else                                          out_byte = ram_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_CTL;
      cnt_q   <= '0;
      rd_q    <= '0;
      csum_q  <= '0;
      patch_q <= 1'b0;
      dv_q    <= 1'b0;
      dd_q    <= '0;
      dl_q    <= 1'b0;
      sent_q  <= 1'b0;
      err_q   <= 1'b0;
      bytes_q <= '0;
    end else begin
      sent_q <= 1'b0;
      err_q  <= cmd_bad;
      case (state_q)
        ST_CTL: begin
          if (cmd_good) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (store) cnt_q <= cnt_q + LW'(1);
          if (din_take && din_last) state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (drop) begin
            cnt_q   <= '0;
            state_q <= ST_CTL;
          end else begin
            csum_q  <= csum_now;
            patch_q <= cmd.ins_en && ((wo_x + XW'(1)) < XW'(cnt_q));
            rd_q    <= '0;
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_LD;
        ST_LD: begin
          dd_q    <= out_byte;
          dl_q    <= (rd_q + LW'(1)) == cnt_q;
          dv_q    <= 1'b1;
          state_q <= ST_OUT;
        end
        ST_OUT: begin
          if (dout_ready) begin
            dv_q <= 1'b0;
            if (dl_q) begin
              bytes_q <= bytes_q + CNT_W'(cnt_q);
              sent_q  <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_CTL;
            end else begin
              rd_q    <= rd_q + LW'(1);
              state_q <= ST_RD;
            end
          end
        end
        default: state_q <= ST_CTL;
      endcase
    end
  end

  assign dout_valid = dv_q;
  assign dout_data  = dd_q;
  assign dout_last  = dl_q;
  assign tx_sent    = sent_q;
  assign ctl_err    = err_q;
  assign tx_bytes   = bytes_q;

endmodule

// File: rtl/csum_tx_engine_chk.sv
module csum_tx_engine_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_ready,
  input logic             din_ready,
  input logic             dout_valid,
  input logic             dout_ready,
  input logic [7:0]       dout_data,
  input logic             dout_last,
  input logic             ctl_err,
  input logic             tx_sent,
  input logic [CNT_W-1:0] tx_bytes
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    dout_valid && !dout_ready |=> dout_valid && $stable(dout_data) && $stable(dout_last));

  assert_sent_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    dout_valid && dout_ready && dout_last |=> tx_sent);

  assert_count_grows_R8: assert property (@(posedge clk) disable iff (rst)
    tx_sent |-> tx_bytes > $past(tx_bytes));

  assert_count_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !tx_sent |-> $stable(tx_bytes));

  assert_err_waits_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_err |-> ctl_ready && !din_ready);

endmodule

bind csum_tx_engine csum_tx_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_ready(ctl_ready), .din_ready(din_ready),
  .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
  .dout_last(dout_last), .ctl_err(ctl_err), .tx_sent(tx_sent),
  .tx_bytes(tx_bytes)
);

// File: tb/sim_csum_tx_engine.sv
module sim_csum_tx_engine;

  localparam int DEPTH = 4096;
  localparam int FMAX  = 4200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_tx_en = 1'b1, cfg_jumbo_en = 1'b0, cfg_vlan_en = 1'b0;
  logic ctl_valid = 1'b0, ctl_last = 1'b0;
  logic [7:0] ctl_data = '0;
  logic ctl_ready, din_ready;
  logic din_valid = 1'b0, din_last = 1'b0;
  logic [7:0] din_data = '0;
  logic dout_valid, dout_last, ctl_err, tx_sent;
  logic dout_ready = 1'b1;
  logic [7:0] dout_data;
  logic [63:0] tx_bytes;

  int checks = 0;
  int errors = 0;
  int olen;
  longint exp_bytes = 0;
  logic [7:0] fbuf [0:FMAX-1];
  logic [7:0] obuf [0:FMAX-1];

  always #4 clk = ~clk;

  csum_tx_engine u0 (
    .clk(clk), .rst(rst), .cfg_tx_en(cfg_tx_en), .cfg_jumbo_en(cfg_jumbo_en),
    .cfg_vlan_en(cfg_vlan_en), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready),
    .ctl_data(ctl_data), .ctl_last(ctl_last), .din_valid(din_valid),
    .din_ready(din_ready), .din_data(din_data), .din_last(din_last),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .dout_last(dout_last), .ctl_err(ctl_err), .tx_sent(tx_sent),
    .tx_bytes(tx_bytes)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic ctl_byte(input logic [7:0] d, input bit l);
    ctl_valid = 1'b1; ctl_data = d; ctl_last = l;
    while (!ctl_ready) @(negedge clk);
    @(negedge clk);
    ctl_valid = 1'b0; ctl_last = 1'b0;
  endtask

  task automatic din_byte(input logic [7:0] d, input bit l);
    din_valid = 1'b1; din_data = d; din_last = l;
    while (!din_ready) @(negedge clk);
    @(negedge clk);
    din_valid = 1'b0; din_last = 1'b0;
  endtask

  task automatic send_ctl(input bit ins, input int start, input int wr,
                          input int seed, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] b;
      case (k)
        0: b = 8'hA4 | {7'd0, ins};
        4: b = wr[7:0];
        5: b = wr[15:8];
        6: b = start[7:0];
        7: b = start[15:8];
        8: b = seed[7:0];
        9: b = seed[15:8];
        default: b = 8'hC3;
      endcase
      ctl_byte(b, k == nbytes - 1);
    end
  endtask

  task automatic fill(input int len, input int salt);
    for (int i = 0; i < len; i++) fbuf[i] = 8'(i * 13 + salt + (i >> 8));
  endtask

  task automatic send_data(input int len);
    for (int i = 0; i < len; i++) din_byte(fbuf[i], i == len - 1);
  endtask

  task automatic receive();
    int guard = 0;
    dout_ready = 1'b1;
    olen = 0;
    while (guard < 20000) begin
      if (dout_valid && dout_ready) begin
        if (olen < FMAX) obuf[olen] = dout_data;
        olen++;
        if (dout_last) break;
      end
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  function automatic logic [15:0] ref_sum(input int len, input int start, input int seed);
    longint s = 0;
    for (int i = start; i < len; i++)
      s += (((i - start) % 2) == 0) ? (longint'(fbuf[i]) << 8) : longint'(fbuf[i]);
    s += longint'(seed & 16'hffff);
    while ((s >> 16) != 0) s = (s & 16'hffff) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic check_frame(input string req, input int len, input bit ins,
                             input int start, input int wr, input int seed);
    int L = (len > DEPTH) ? DEPTH : len;
    logic [15:0] c = ref_sum(L, start, seed);
    bit pt = ins && (wr + 1 < L);
    int bad = -1;
    logic [7:0] eb = '0;
    chk(olen == L, req, "output length", olen, L);
    for (int i = 0; i < L; i++) begin
      logic [7:0] e = fbuf[i];
      if (pt && i == wr) e = c[15:8];
      if (pt && i == wr + 1) e = c[7:0];
      if (bad < 0 && obuf[i] !== e) begin bad = i; eb = e; end
    end
    chk(bad < 0, req, $sformatf("content byte %0d", bad),
        (bad < 0) ? 0 : obuf[bad], eb);
  endtask

  task automatic run_frame(input string req, input int len, input bit ins,
                           input int start, input int wr, input int seed, input int salt);
    send_ctl(ins, start, wr, seed, 20);
    fill(len, salt);
    send_data(len);
    receive();
    check_frame(req, len, ins, start, wr, seed);
    exp_bytes += (len > DEPTH) ? DEPTH : len;
    chk(tx_sent == 1'b1, "R8", "tx_sent after frame", tx_sent, 1);
    chk(tx_bytes == exp_bytes, "R8", "tx_bytes total", tx_bytes, exp_bytes);
  endtask

  task automatic expect_drop(input string req, input int len, input int salt);
    bit seen = 1'b0;
    send_ctl(1'b1, 14, 20, 16'h0F0F, 20);
    fill(len, salt);
    send_data(len);
    repeat (30) begin
      @(negedge clk);
      if (dout_valid) seen = 1'b1;
    end
    chk(!seen, req, $sformatf("no output for %0d-byte frame", len), seen, 0);
    chk(tx_bytes == exp_bytes, req, "counter unchanged on drop", tx_bytes, exp_bytes);
    chk(ctl_ready == 1'b1, req, "ready for next command", ctl_ready, 1);
  endtask

  task automatic t_reset();
    chk(tx_bytes == 0, "R11", "tx_bytes after reset", tx_bytes, 0);
    chk(dout_valid == 1'b0, "R11", "dout_valid after reset", dout_valid, 0);
    chk(ctl_ready == 1'b1 && din_ready == 1'b0, "R11", "ready pair after reset",
        {ctl_ready, din_ready}, 2'b10);
    chk(tx_sent == 1'b0 && ctl_err == 1'b0, "R11", "flags after reset",
        {tx_sent, ctl_err}, 0);
  endtask

  task automatic t_basic();
    run_frame("R1 R3", 60, 1'b1, 14, 24, 16'h1234, 3);
    @(negedge clk);
    chk(tx_sent == 1'b0, "R8", "tx_sent one cycle only", tx_sent, 0);
    run_frame("R3 odd length odd start", 61, 1'b1, 15, 40, 16'hFFFF, 77);
    run_frame("R3 seed carry", 33, 1'b1, 0, 2, 16'hFFFE, 200);
  endtask

  task automatic t_noins();
    run_frame("R4", 64, 1'b0, 14, 24, 16'hBEEF, 9);
  endtask

  task automatic t_edge();
    run_frame("R5 wr at last byte", 40, 1'b1, 10, 39, 16'h0101, 5);
    run_frame("R5 wr one before last", 40, 1'b1, 10, 38, 16'h0101, 6);
  endtask

  task automatic t_start_past();
    run_frame("R12", 30, 1'b1, 45, 4, 16'h5A5A, 11);
  endtask

  task automatic t_txoff();
    cfg_tx_en = 1'b0;
    expect_drop("R6", 50, 21);
    cfg_tx_en = 1'b1;
    run_frame("R6 re-enabled", 50, 1'b1, 14, 20, 16'h0F0F, 21);
  endtask

  task automatic t_size();
    run_frame("R7 1518 sent", 1518, 1'b1, 14, 30, 16'h0001, 31);
    expect_drop("R7 1519 dropped", 1519, 32);
    expect_drop("R7 1522 dropped", 1522, 33);
    cfg_vlan_en = 1'b1;
    run_frame("R7 1522 vlan sent", 1522, 1'b1, 14, 1520, 16'h0002, 34);
    cfg_vlan_en = 1'b0;
    cfg_jumbo_en = 1'b1;
    run_frame("R7 1520 jumbo sent", 1520, 1'b0, 14, 30, 16'h0003, 35);
    cfg_jumbo_en = 1'b0;
    run_frame("R7 1523 sent", 1523, 1'b1, 100, 200, 16'h0004, 36);
  endtask

  task automatic t_trunc();
    run_frame("R9", 4100, 1'b1, 4000, 4094, 16'h2222, 41);
  endtask

  task automatic t_ctlerr();
    send_ctl(1'b1, 14, 20, 16'h1111, 19);
    chk(ctl_err == 1'b1, "R2", "error after 19 bytes", ctl_err, 1);
    chk(din_ready == 1'b0, "R2", "no data accepted after short command", din_ready, 0);
    @(negedge clk);
    chk(ctl_err == 1'b0, "R2", "error is one cycle", ctl_err, 0);
    send_ctl(1'b1, 14, 20, 16'h1111, 21);
    chk(ctl_err == 1'b1, "R2", "error after 21 bytes", ctl_err, 1);
    chk(din_ready == 1'b0 && ctl_ready == 1'b1, "R2", "still waiting for command",
        {din_ready, ctl_ready}, 2'b01);
    @(negedge clk);
    run_frame("R2 recovery", 48, 1'b1, 14, 20, 16'h1111, 51);
  endtask

  task automatic t_backpressure();
    int guard = 0;
    int moved = 0;
    logic [7:0] held;
    logic hl;
    send_ctl(1'b1, 2, 0, 16'h0000, 20);
    fill(20, 61);
    dout_ready = 1'b0;
    send_data(20);
    while (!dout_valid && guard < 100) begin @(negedge clk); guard++; end
    held = dout_data; hl = dout_last;
    repeat (4) begin
      @(negedge clk);
      if (!dout_valid || dout_data !== held || dout_last !== hl) moved++;
    end
    chk(moved == 0 && guard < 100, "R10", "output held under back-pressure", moved, 0);
    receive();
    check_frame("R10 frame", 20, 1'b1, 2, 0, 16'h0000);
    exp_bytes += 20;
    chk(tx_bytes == exp_bytes, "R8", "tx_bytes after stalled frame", tx_bytes, exp_bytes);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_noins();
    t_edge();
    t_start_past();
    t_ctlerr();
    t_txoff();
    t_backpressure();
    t_size();
    t_trunc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule